// File: doc/BRIEF.md
# Configurable-length SPI shift engine

This block is a single SPI port that works either as the clock-generating master or as a selected slave. Each transfer moves one word of 8 to 16 bits. The width, the sampling phase, the idle clock level, the role and the shift direction all come from a set of static configuration inputs. In master role a one-cycle start strobe launches a transfer of the parallel transmit word. In slave role an external master frames and clocks the transfer. At the end of a transfer the received word is presented in parallel, right-aligned.

Completion and a mode fault each set a sticky flag that stays up until the clear input is pulsed. An interrupt output follows the two flags when interrupts are enabled. A mode fault occurs when another master drives the select input while this port is master. It cancels the running transfer, and the port acts as a slave until the fault flag is cleared.

Top module: `spi_shift_engine`

## Requirements
- R1: With `cfg_len_en` = 0 every transfer is 8 bits, whatever `cfg_len_code` holds.
- R2: With `cfg_len_en` = 1, `cfg_len_code` 4'b1000..4'b1111 selects 8..15 bits, 4'b0000 selects 16 bits, and 4'b0001..4'b0111 select 8 bits. Only the low N bits of `tx_word` are sent, and `rx_word` holds the N received bits right-aligned with zeros above them.
- R3: While no master transfer is running, `sck_out` equals `cfg_cpol` (0 idles low, 1 idles high). An edge is leading when SCK moves away from that idle level.
- R4: As master, a transfer produces exactly 2N SCK edges spaced `CLK_DIV`/2 system clocks apart. With `cfg_cpha` = 0, each bit is on `mosi_out` before its leading edge and `miso_in` is sampled on the leading edge. With `cfg_cpha` = 1, `mosi_out` changes on the leading edge and is sampled on the trailing edge.
- R5: `cfg_lsb_first` = 0 shifts bit N-1 first. `cfg_lsb_first` = 1 shifts bit 0 first. This holds for both directions and both roles.
- R6: `cfg_master` = 1 selects master role and 0 selects slave role. As master, `ssel_out_n` is 0 from the cycle after `start` until the last SCK edge of the transfer. At all other times, and always in slave role, it is 1.
- R7: As a slave with `cfg_cpha` = 0, the first bit appears on `miso_out` when `ssel_in_n` falls. `mosi_in` is sampled on leading edges. Completion is signalled only when `ssel_in_n` rises after N bits.
- R8: As a slave with `cfg_cpha` = 1, a word starts on a leading edge while `ssel_in_n` is 0 and completes on the Nth trailing edge, without waiting for `ssel_in_n` to rise.
- R9: Completion sets `done_flag` and loads `rx_word`. A pulse on `flag_clr` clears both flags. A flag being set in the same cycle wins over the clear.
- R10: In master role, `ssel_in_n` = 0 sets `fault_flag`, ends any transfer with SCK back at idle and `ssel_out_n` = 1, and makes the port behave as a slave until `fault_flag` is cleared.
- R11: `irq` is 1 exactly when `cfg_irq_en` = 1 and `done_flag` or `fault_flag` is set. With `cfg_irq_en` = 0, `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_len_en | input | 1 | 1: use the length code, 0: fixed 8 bits |
| cfg_len_code | input | 4 | Word length code |
| cfg_cpha | input | 1 | Clock phase: 0 sample on leading edge, 1 sample on trailing edge |
| cfg_cpol | input | 1 | Idle SCK level |
| cfg_master | input | 1 | 1 master, 0 slave |
| cfg_lsb_first | input | 1 | 1 LSB first, 0 MSB first |
| cfg_irq_en | input | 1 | Interrupt enable |
| tx_word | input | 16 | Word to send, right-aligned |
| start | input | 1 | Master transfer launch strobe |
| flag_clr | input | 1 | Clears both flags |
| rx_word | output | 16 | Last received word, right-aligned |
| done_flag | output | 1 | Sticky transfer-complete flag |
| fault_flag | output | 1 | Sticky mode-fault flag |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | Serial clock from an external master |
| sck_out | output | 1 | Serial clock in master role |
| mosi_in | input | 1 | Serial data in (slave role) |
| mosi_out | output | 1 | Serial data out (master role) |
| miso_in | input | 1 | Serial data in (master role) |
| miso_out | output | 1 | Serial data out (slave role) |
| ssel_in_n | input | 1 | Select input, active low |
| ssel_out_n | output | 1 | Select output, active low |

## Verification
The assertions watch the properties that hold on every cycle. These are the idle clock level, the minimum spacing of SCK edges while a transfer runs, the select output in slave role and after a fault, the interrupt gating, and the release of the select output when a master transfer completes. Only the bench scenarios can show the content of a transfer. That covers the decoded word length as a count of edges, the bit order seen on the data pin, the received value, the slave framing in each phase and the cancelling effect of a fault. These depend on whole sequences of pin activity.

// File: rtl/spi_eng_pkg.sv
// Package: types and helpers shared by the SPI shift engine.
// Assumes words of at most 16 bits, because the length code 0000 means 16.
package spi_eng_pkg;
    localparam int MAX_BITS = 16;
    localparam int IDX_W    = $clog2(MAX_BITS + 1);

    typedef logic [IDX_W-1:0] bitcnt_t;

    localparam bitcnt_t ONE = bitcnt_t'(1);

    // Wire position of the bit shifted at step idx of an n-bit word.
    function automatic bitcnt_t bit_pos(bitcnt_t idx, bitcnt_t n, logic lsb_first);
        return lsb_first ? idx : (n - idx - ONE);
    endfunction

    // Select the bit of w that goes out at step idx.
    function automatic logic pick_bit(logic [MAX_BITS-1:0] w, bitcnt_t idx,
                                      bitcnt_t n, logic lsb_first);
        bitcnt_t p;
        p = bit_pos(idx, n, lsb_first);
        return w[p[3:0]];
    endfunction
endpackage

// File: rtl/spi_len_decode.sv
// Turns the enable bit and the 4-bit length code into a bit count.
// Assumes undefined codes 0001..0111 fall back to 8 bits.
module spi_len_decode
    import spi_eng_pkg::*;
(
    input  logic       len_en,
    input  logic [3:0] len_code,
    output bitcnt_t    nbits
);
    // Map the code to the number of bits per word.
    always_comb begin
        if (!len_en)
            nbits = bitcnt_t'(8);
        else if (len_code == 4'b0000)
            nbits = bitcnt_t'(16);
        else if (len_code[3])
            nbits = bitcnt_t'(len_code);
        else
            nbits = bitcnt_t'(8);
    end
endmodule

// File: rtl/spi_pin_sync.sv
// Multi-flop synchronizer for asynchronous pin inputs.
// Assumes STAGES >= 2. Each bit resets to its own RST_VAL bit.
module spi_pin_sync #(
    parameter int               WIDTH   = 3,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain;
        // Shift the pin level through the flop chain.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain <= {STAGES{RST_VAL[g]}};
            else
                chain <= {chain[STAGES-2:0], din[g]};
        end
        assign dout[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/spi_sck_gen.sv
// Master bit-clock timer: pulses tick every DIV/2 system clocks while run is high.
// Assumes DIV is even and at least 8.
module spi_sck_gen #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int HALF = DIV / 2;
    localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    // Count system clocks within one SCK half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            cnt <= '0;
        else if (cnt == CW'(HALF - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == CW'(HALF - 1));
endmodule

// File: rtl/spi_shift_engine.sv
// SPI shift engine for master or slave role with 8..16-bit words.
// Assumes the cfg_* inputs change only while no transfer runs. Pins used
// in slave role pass through a two-flop synchronizer.
module spi_shift_engine
    import spi_eng_pkg::*;
#(
    parameter int CLK_DIV     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_len_en,
    input  logic [3:0]  cfg_len_code,
    input  logic        cfg_cpha,
    input  logic        cfg_cpol,
    input  logic        cfg_master,
    input  logic        cfg_lsb_first,
    input  logic        cfg_irq_en,
    input  logic [15:0] tx_word,
    input  logic        start,
    input  logic        flag_clr,
    output logic [15:0] rx_word,
    output logic        done_flag,
    output logic        fault_flag,
    output logic        irq,
    input  logic        sck_in,
    output logic        sck_out,
    input  logic        mosi_in,
    output logic        mosi_out,
    input  logic        miso_in,
    output logic        miso_out,
    input  logic        ssel_in_n,
    output logic        ssel_out_n
);
    bitcnt_t     nbits;
    bitcnt_t     idx;
    logic [2:0]  sync_q;
    logic        sck_s, mosi_s, ssel_s;
    logic        sck_prev, ssel_prev;
    logic        busy, level, tick, out_bit;
    logic [15:0] tx_lat, rx_acc, rx_ins;
    bitcnt_t     pos_cur;

    spi_len_decode u_len (
        .len_en   (cfg_len_en),
        .len_code (cfg_len_code),
        .nbits    (nbits)
    );

    spi_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ssel_in_n, mosi_in, sck_in}),
        .dout  (sync_q)
    );
    assign {ssel_s, mosi_s, sck_s} = sync_q;

    spi_sck_gen #(.DIV(CLK_DIV)) u_sck (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    logic eff_master, s_lead, s_trail, ssel_rise, ssel_fall, samp_val;

    // Role and pin events derived from the synchronized slave pins.
    always_comb begin
        eff_master = cfg_master && !fault_flag;
        s_lead     = (sck_s != sck_prev) && (sck_s != cfg_cpol);
        s_trail    = (sck_s != sck_prev) && (sck_s == cfg_cpol);
        ssel_rise  = ssel_s && !ssel_prev;
        ssel_fall  = !ssel_s && ssel_prev;
        samp_val   = eff_master ? miso_in : mosi_s;
    end

    // Word with the currently sampled bit inserted at its position.
    always_comb begin
        pos_cur = bit_pos(idx, nbits, cfg_lsb_first);
        rx_ins  = rx_acc;
        rx_ins[pos_cur[3:0]] = samp_val;
    end

    // Transfer sequencing for master and slave roles, and the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; level <= 1'b0; idx <= '0; out_bit <= 1'b0;
            tx_lat <= '0; rx_acc <= '0; rx_word <= '0;
            done_flag <= 1'b0; fault_flag <= 1'b0;
            sck_prev <= 1'b0; ssel_prev <= 1'b1;
        end else begin
            sck_prev  <= sck_s;
            ssel_prev <= ssel_s;
            if (flag_clr) begin
                done_flag  <= 1'b0;
                fault_flag <= 1'b0;
            end
            if (eff_master && !ssel_s) begin
                fault_flag <= 1'b1;
                busy       <= 1'b0;
                level      <= 1'b0;
            end else if (eff_master) begin
                if (!busy) begin
                    if (start) begin
                        busy   <= 1'b1;
                        level  <= 1'b0;
                        idx    <= '0;
                        tx_lat <= tx_word;
                        rx_acc <= '0;
                        if (!cfg_cpha)
                            out_bit <= pick_bit(tx_word, '0, nbits, cfg_lsb_first);
                    end
                end else if (tick) begin
                    level <= ~level;
                    if (!level) begin
                        if (!cfg_cpha) rx_acc  <= rx_ins;
                        else           out_bit <= pick_bit(tx_lat, idx, nbits, cfg_lsb_first);
                    end else begin
                        if (cfg_cpha) rx_acc <= rx_ins;
                        if (idx == nbits - ONE) begin
                            busy      <= 1'b0;
                            done_flag <= 1'b1;
                            rx_word   <= cfg_cpha ? rx_ins : rx_acc;
                        end else begin
                            idx <= idx + ONE;
                            if (!cfg_cpha)
                                out_bit <= pick_bit(tx_lat, idx + ONE, nbits, cfg_lsb_first);
                        end
                    end
                end
            end else begin
                busy  <= 1'b0;
                level <= 1'b0;
                if (ssel_s) begin
                    if (ssel_rise && !cfg_cpha && idx == nbits) begin
                        done_flag <= 1'b1;
                        rx_word   <= rx_acc;
                    end
                    idx <= '0;
                end else if (!cfg_cpha) begin
                    if (ssel_fall) begin
                        tx_lat  <= tx_word;
                        rx_acc  <= '0;
                        idx     <= '0;
                        out_bit <= pick_bit(tx_word, '0, nbits, cfg_lsb_first);
                    end else if (s_lead && idx < nbits) begin
                        rx_acc <= rx_ins;
                    end else if (s_trail && idx < nbits) begin
                        idx <= idx + ONE;
                        if (idx + ONE < nbits)
                            out_bit <= pick_bit(tx_lat, idx + ONE, nbits, cfg_lsb_first);
                    end
                end else begin
                    if (s_lead) begin
                        if (idx == '0) begin
                            tx_lat  <= tx_word;
                            rx_acc  <= '0;
                            out_bit <= pick_bit(tx_word, '0, nbits, cfg_lsb_first);
                        end else begin
                            out_bit <= pick_bit(tx_lat, idx, nbits, cfg_lsb_first);
                        end
                    end else if (s_trail) begin
                        rx_acc <= rx_ins;
                        if (idx == nbits - ONE) begin
                            done_flag <= 1'b1;
                            rx_word   <= rx_ins;
                            idx       <= '0;
                        end else begin
                            idx <= idx + ONE;
                        end
                    end
                end
            end
        end
    end

    assign sck_out    = cfg_cpol ^ level;
    assign ssel_out_n = ~busy;
    assign mosi_out   = out_bit;
    assign miso_out   = out_bit;
    assign irq        = cfg_irq_en && (done_flag || fault_flag);
endmodule

// File: rtl/spi_shift_engine_chk.sv
// Checker for spi_shift_engine: temporal properties on its ports.
// Assumes the cfg_* inputs are held steady while a transfer runs.
module spi_shift_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_cpol,
    input logic cfg_master,
    input logic cfg_irq_en,
    input logic done_flag,
    input logic fault_flag,
    input logic irq,
    input logic sck_out,
    input logic ssel_out_n
);
    // Idle SCK sits at the polarity level.
    assert_sck_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ssel_out_n |-> sck_out == cfg_cpol);

    // An SCK edge inside a transfer is never followed by another edge one cycle later.
    assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ssel_out_n && !$past(ssel_out_n) && sck_out != $past(sck_out)) |=> $stable(sck_out));

    // Slave role never drives its own select.
    assert_slave_no_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_master |-> ssel_out_n);

    // A master completion releases the select output in the same cycle.
    assert_done_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !fault_flag && $rose(done_flag)) |-> $rose(ssel_out_n));

    // A fault leaves the select output released.
    assert_fault_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> ssel_out_n);

    // Interrupt is silent when disabled.
    assert_irq_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_irq_en |-> !irq);

    // Interrupt follows a new completion when enabled.
    assert_irq_on_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_en && ($rose(done_flag) || $rose(fault_flag))) |-> irq);
endmodule

bind spi_shift_engine spi_shift_engine_chk u_chk (.*);

// File: tb/spi_shift_engine_test.sv
// Directed bench for spi_shift_engine: one task per scenario.
module spi_shift_engine_test;
    localparam int DIV = 8;
    localparam int HB  = 12;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, cfg_len_en, cfg_cpha, cfg_cpol, cfg_master, cfg_lsb_first, cfg_irq_en;
    logic [3:0]  cfg_len_code;
    logic [15:0] tx_word, rx_word;
    logic        start, flag_clr, done_flag, fault_flag, irq;
    logic        sck_in, sck_out, mosi_in, mosi_out, miso_in, miso_out, ssel_in_n, ssel_out_n;
    logic        loop_inv;

    assign miso_in = loop_inv ? ~mosi_out : mosi_out;

    spi_shift_engine #(.CLK_DIV(DIV)) uut (.*);

    int tests = 0, fails = 0;

    task automatic check(string req, string what, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Pin monitor for master transfers.
    logic       mon_prev;
    int         edges, ncap, gap, min_gap;
    logic [0:31] cap_bits;
    always @(negedge clk) begin
        gap++;
        if (sck_out !== mon_prev) begin
            if (edges > 0 && gap < min_gap) min_gap = gap;
            gap = 0;
            edges++;
            if ((sck_out != cfg_cpol) ^ cfg_cpha) begin
                cap_bits[ncap] = mosi_out;
                ncap++;
            end
        end
        mon_prev = sck_out;
    end

    function automatic logic [15:0] mask_of(int n);
        return (n == 16) ? 16'hFFFF : 16'((1 << n) - 1);
    endfunction

    task automatic clear_flags();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic master_xfer(string req, logic len_en, logic [3:0] code, int n,
                               logic cpha, logic cpol, logic lsb, logic inv,
                               logic ien, logic [15:0] tx);
        logic [15:0] got;
        int t;
        @(negedge clk);
        cfg_master = 1'b1; cfg_len_en = len_en; cfg_len_code = code; cfg_cpha = cpha;
        cfg_cpol = cpol; cfg_lsb_first = lsb; cfg_irq_en = ien; loop_inv = inv; tx_word = tx;
        repeat (3) @(negedge clk);
        edges = 0; ncap = 0; gap = 0; min_gap = 999; mon_prev = sck_out;
        check("R3", "idle sck", int'(sck_out), int'(cpol));
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        check("R6", "select active", int'(ssel_out_n), 0);
        t = 0;
        while (!done_flag && t < 2000) begin @(negedge clk); t++; end
        @(negedge clk);
        check(req, "done", int'(done_flag), 1);
        check(req, "edge count (R4)", edges, 2 * n);
        check("R4", "half period", min_gap, DIV / 2);
        check(req, "bits out", ncap, n);
        got = '0;
        for (int k = 0; k < ncap && k < 16; k++)
            got[lsb ? k : n - 1 - k] = cap_bits[k];
        check("R5", "word on mosi", int'(got), int'(tx & mask_of(n)));
        check(req, "rx_word (R9)", int'(rx_word), int'((inv ? ~tx : tx) & mask_of(n)));
        check("R6", "select released", int'(ssel_out_n), 1);
        check("R3", "sck back idle", int'(sck_out), int'(cpol));
        check("R11", "irq", int'(irq), int'(ien));
        clear_flags();
        check("R9", "flag cleared", int'(done_flag), 0);
    endtask

    task automatic slave_xfer(string req, int n, logic cpha, logic cpol, logic lsb,
                              logic [15:0] mw, logic [15:0] sw);
        logic [15:0] got;
        int p;
        @(negedge clk);
        cfg_master = 1'b0; cfg_len_en = 1'b1; cfg_len_code = (n == 16) ? 4'h0 : 4'(n);
        cfg_cpha = cpha; cfg_cpol = cpol; cfg_lsb_first = lsb; cfg_irq_en = 1'b1;
        tx_word = sw; sck_in = cpol; mosi_in = 1'b0; ssel_in_n = 1'b1;
        repeat (6) @(negedge clk);
        ssel_in_n = 1'b0;
        got = '0;
        for (int k = 0; k < n; k++) begin
            p = lsb ? k : n - 1 - k;
            if (!cpha) begin
                mosi_in = mw[p];
                repeat (HB) @(negedge clk);
                got[p] = miso_out;
                sck_in = ~cpol;
                repeat (HB) @(negedge clk);
                sck_in = cpol;
            end else begin
                repeat (HB) @(negedge clk);
                sck_in = ~cpol;
                mosi_in = mw[p];
                repeat (HB) @(negedge clk);
                got[p] = miso_out;
                sck_in = cpol;
            end
        end
        if (!cpha) begin
            repeat (HB) @(negedge clk);
            check(req, "no done while selected", int'(done_flag), 0);
            ssel_in_n = 1'b1;
            repeat (6) @(negedge clk);
            check(req, "done after deselect", int'(done_flag), 1);
        end else begin
            repeat (6) @(negedge clk);
            check(req, "done on last trailing edge", int'(done_flag), 1);
            ssel_in_n = 1'b1;
            repeat (6) @(negedge clk);
        end
        check(req, "rx_word (R2)", int'(rx_word), int'(mw & mask_of(n)));
        check("R5", "word on miso", int'(got), int'(sw & mask_of(n)));
        check("R6", "slave select idle", int'(ssel_out_n), 1);
        clear_flags();
    endtask

    task automatic fault_case();
        @(negedge clk);
        cfg_master = 1'b1; cfg_len_en = 1'b1; cfg_len_code = 4'h0; cfg_cpha = 1'b0;
        cfg_cpol = 1'b1; cfg_lsb_first = 1'b0; cfg_irq_en = 1'b1; tx_word = 16'hBEEF;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        check("R10", "busy before fault", int'(ssel_out_n), 0);
        ssel_in_n = 1'b0;
        repeat (5) @(negedge clk);
        check("R10", "fault flag", int'(fault_flag), 1);
        check("R10", "select released", int'(ssel_out_n), 1);
        check("R10", "sck idle", int'(sck_out), 1);
        check("R10", "no done", int'(done_flag), 0);
        check("R11", "irq on fault", int'(irq), 1);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", "start ignored in forced slave", int'(ssel_out_n), 1);
        ssel_in_n = 1'b1;
        repeat (4) @(negedge clk);
        clear_flags();
        check("R9", "fault cleared", int'(fault_flag), 0);
        check("R11", "irq cleared", int'(irq), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_len_en = 1'b0; cfg_len_code = 4'h0; cfg_cpha = 1'b0; cfg_cpol = 1'b0;
        cfg_master = 1'b0; cfg_lsb_first = 1'b0; cfg_irq_en = 1'b0; tx_word = '0;
        start = 1'b0; flag_clr = 1'b0; sck_in = 1'b0; mosi_in = 1'b0; ssel_in_n = 1'b1;
        loop_inv = 1'b0; mon_prev = 1'b0; edges = 0; ncap = 0; gap = 0; min_gap = 999;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", "reset done", int'(done_flag), 0);
        check("R10", "reset fault", int'(fault_flag), 0);
        check("R9", "reset rx", int'(rx_word), 0);
        check("R6", "reset select", int'(ssel_out_n), 1);
        check("R3", "reset sck", int'(sck_out), 0);
        master_xfer("R1", 1'b0, 4'h0, 8,  1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3);
        master_xfer("R2", 1'b1, 4'h0, 16, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 16'h1234);
        master_xfer("R2", 1'b1, 4'hC, 12, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 16'h0ABC);
        master_xfer("R2", 1'b1, 4'h3, 8,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0F5A);
        master_xfer("R4", 1'b1, 4'hF, 15, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 16'h7E81);
        slave_xfer("R7", 8,  1'b0, 1'b0, 1'b0, 16'h0096, 16'h003C);
        slave_xfer("R8", 12, 1'b1, 1'b1, 1'b1, 16'h0A5F, 16'h0C33);
        slave_xfer("R7", 16, 1'b0, 1'b1, 1'b1, 16'hC3E1, 16'h5AA7);
        fault_case();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule